// File: doc/BRIEF.md
# Interrupt Register Access Trap Decoder

This block sits next to the CPU interface of an interrupt controller and judges every system-register access. An access can complete normally, trap to the hypervisor level, or go to the virtual register bank in place of the physical one. The judgement is made from four things: the class of the register being accessed, the exception level and security state of the requester, and a set of hypervisor control bits.

Traps apply only to accesses made at level 1 in the non-secure state. Each register class has its own set of control bits that cause a trap. When either routing bit (IRQ or FIQ) is set and no trap is taken, the access is redirected. The result is registered. It appears for one cycle, one clock after the access strobe, and carries a reason code that names the control bit responsible.

Top module: `irq_acc_trap_dec`

## Requirements
- R1: After a synchronous reset, and in every cycle that does not directly follow a strobe, `res_valid`, `res_trap` and `res_redir` are 0 and `res_why` is 0 (NONE).
- R2: The result for a strobe in cycle N appears in cycle N+1, with `res_valid` high for exactly that one cycle.
- R3: An access that is not at level 1 (`acc_el` not equal to 1), or that is made in the secure state (`acc_secure`=1), never traps and is never redirected.
- R4: Class 0 (group-0-only registers) traps when `hc_tall0` is set. Class 1 (group-1-only registers) traps when `hc_tall1` is set.
- R5: Class 2 (deactivate) traps when `hc_tc` or `hc_tdir` is set.
- R6: Class 3 (priority mask, running priority, control) traps only when `hc_tc` is set.
- R7: Class 4 (software-generated interrupt registers) traps when `hc_tc`, `hc_imo` or `hc_fmo` is set.
- R8: Class 5, and the reserved codes 6 and 7, never trap.
- R9: A non-secure level-1 access that does not trap is redirected when `hc_imo` or `hc_fmo` is set. A trap suppresses the redirect, so `res_trap` and `res_redir` are never both 1.
- R10: On a trap, `res_why` gives the cause as 1=trap-all, 2=deactivate trap, 3=common trap, 4=routing bits. When more than one applies, the lowest of these numbers wins. `res_why` is 0 when there is no trap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_stb | input | 1 | Access strobe, one access per high cycle |
| acc_cls | input | 3 | Register class code |
| acc_el | input | 2 | Exception level of the requester |
| acc_secure | input | 1 | Requester is in the secure state |
| hc_tall0 | input | 1 | Trap-all control for group 0 |
| hc_tall1 | input | 1 | Trap-all control for group 1 |
| hc_tc | input | 1 | Common trap control |
| hc_tdir | input | 1 | Deactivate trap control |
| hc_imo | input | 1 | IRQ routing control |
| hc_fmo | input | 1 | FIQ routing control |
| res_valid | output | 1 | Result valid |
| res_trap | output | 1 | Access traps to level 2 |
| res_redir | output | 1 | Access is redirected to the virtual bank |
| res_why | output | 3 | Trap reason code |

## Verification
The bench drives every combination of class, level, security state and control bits, then adds random streams of strobes with gaps between them. Several corner cases get direct attention:
- A class-4 access with only a routing bit set must trap and must not redirect. A design that checks the redirect first would raise both outputs.
- A class-2 access with both `hc_tc` and `hc_tdir` set must report the deactivate reason. A design with the priority swapped would report the common-trap reason.
- Secure and level-2 accesses with every control bit set would trap if the level qualifier were lost.
- The reserved class codes would trap if they were mapped onto a real class.

// File: rtl/irq_acc_trap_pkg.sv
package irq_acc_trap_pkg;
  localparam int CLS_W = 3;
  localparam int EL_W  = 2;
  localparam int WHY_W = 3;

  typedef enum logic [CLS_W-1:0] {
    CLS_G0   = 3'd0,
    CLS_G1   = 3'd1,
    CLS_DEACT= 3'd2,
    CLS_PRI  = 3'd3,
    CLS_SGI  = 3'd4,
    CLS_FREE = 3'd5,
    CLS_RSV6 = 3'd6,
    CLS_RSV7 = 3'd7
  } reg_cls_e;

  typedef enum logic [WHY_W-1:0] {
    WHY_NONE  = 3'd0,
    WHY_TALL  = 3'd1,
    WHY_TDIR  = 3'd2,
    WHY_TC    = 3'd3,
    WHY_ROUTE = 3'd4
  } trap_why_e;

  typedef struct packed {
    logic tall0;
    logic tall1;
    logic tc;
    logic tdir;
    logic imo;
    logic fmo;
  } hyp_ctl_t;

  typedef struct packed {
    logic      trap;
    logic      redir;
    trap_why_e why;
  } verdict_t;
endpackage

// File: rtl/irq_acc_cause_map.sv
// Gives, for each register class, which cause sources are active.
module irq_acc_cause_map
  import irq_acc_trap_pkg::*;
#(
  parameter int NCAUSE = 4
) (
  input  logic [CLS_W-1:0]  cls,
  input  hyp_ctl_t          ctl,
  output logic [NCAUSE-1:0] hit
);
  // bit 0 trap-all, bit 1 deactivate, bit 2 common, bit 3 routing
  always_comb begin
    hit = '0;
    unique case (cls)
      CLS_G0:    hit[0] = ctl.tall0;
      CLS_G1:    hit[0] = ctl.tall1;
      CLS_DEACT: begin
        hit[1] = ctl.tdir;
        hit[2] = ctl.tc;
      end
      CLS_PRI:   hit[2] = ctl.tc;
      CLS_SGI: begin
        hit[2] = ctl.tc;
        hit[3] = ctl.imo | ctl.fmo;
      end
      default:   hit = '0;
    endcase
  end
endmodule

// File: rtl/irq_acc_prio_pick.sv
// Picks the lowest-index active cause and gives its reason code.
module irq_acc_prio_pick
  import irq_acc_trap_pkg::*;
#(
  parameter int NCAUSE = 4
) (
  input  logic [NCAUSE-1:0] hit,
  output logic              any,
  output trap_why_e         why
);
  logic [NCAUSE-1:0] first;
  logic [NCAUSE:0]   seen;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NCAUSE; i++) begin : g_scan
    assign first[i]  = hit[i] & ~seen[i];
    assign seen[i+1] = seen[i] | hit[i];
  end

  assign any = seen[NCAUSE];

  always_comb begin
    why = WHY_NONE;
    for (int i = 0; i < NCAUSE; i++)
      if (first[i]) why = trap_why_e'(WHY_W'(i + 1));
  end
endmodule

// File: rtl/irq_acc_trap_dec.sv
module irq_acc_trap_dec
  import irq_acc_trap_pkg::*;
#(
  parameter int          NCAUSE   = 4,
  parameter logic [1:0]  GUEST_EL = 2'd1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc_stb,
  input  logic [CLS_W-1:0] acc_cls,
  input  logic [EL_W-1:0]  acc_el,
  input  logic             acc_secure,
  input  logic             hc_tall0,
  input  logic             hc_tall1,
  input  logic             hc_tc,
  input  logic             hc_tdir,
  input  logic             hc_imo,
  input  logic             hc_fmo,
  output logic             res_valid,
  output logic             res_trap,
  output logic             res_redir,
  output logic [WHY_W-1:0] res_why
);
  hyp_ctl_t          ctl;
  logic [NCAUSE-1:0] hit;
  logic              any;
  trap_why_e         why;
  logic              guest;
  verdict_t          nxt, cur;
  logic              vld_q;

  assign ctl = '{tall0: hc_tall0, tall1: hc_tall1, tc: hc_tc,
                 tdir: hc_tdir, imo: hc_imo, fmo: hc_fmo};
  assign guest = (acc_el == GUEST_EL) && !acc_secure;

  irq_acc_cause_map #(.NCAUSE(NCAUSE)) u_map (
    .cls(acc_cls), .ctl(ctl), .hit(hit)
  );

  irq_acc_prio_pick #(.NCAUSE(NCAUSE)) u_pick (
    .hit(hit), .any(any), .why(why)
  );

  always_comb begin
    nxt = '{trap: 1'b0, redir: 1'b0, why: WHY_NONE};
    if (acc_stb && guest) begin
      if (any) begin
        nxt.trap = 1'b1;
        nxt.why  = why;
      end else if (hc_imo || hc_fmo) begin
        nxt.redir = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q <= 1'b0;
      cur   <= '{trap: 1'b0, redir: 1'b0, why: WHY_NONE};
    end else begin
      vld_q <= acc_stb;
      cur   <= nxt;
    end
  end

  assign res_valid = vld_q;
  assign res_trap  = cur.trap;
  assign res_redir = cur.redir;
  assign res_why   = cur.why;
endmodule

// File: rtl/irq_acc_trap_chk.sv
module irq_acc_trap_chk (
  input logic       clk,
  input logic       rst,
  input logic       acc_stb,
  input logic [2:0] acc_cls,
  input logic [1:0] acc_el,
  input logic       acc_secure,
  input logic       hc_tc,
  input logic       res_valid,
  input logic       res_trap,
  input logic       res_redir,
  input logic [2:0] res_why
);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !res_valid |-> (!res_trap && !res_redir && res_why == 3'd0));
  // R2
  one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    acc_stb |=> res_valid);
  // R3
  host_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_stb && (acc_el != 2'd1 || acc_secure)) |=> (!res_trap && !res_redir));
  // R6
  pri_tc_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_stb && acc_el == 2'd1 && !acc_secure && acc_cls == 3'd3 && hc_tc)
      |=> (res_trap && res_why == 3'd3));
  // R8
  free_cls_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_stb && acc_cls >= 3'd5) |=> !res_trap);
  // R9
  excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(res_trap && res_redir));
  // R10
  why_trap_chk: assert property (@(posedge clk) disable iff (rst)
    res_trap == (res_why != 3'd0));
endmodule

bind irq_acc_trap_dec irq_acc_trap_chk u_chk (
  .clk(clk), .rst(rst), .acc_stb(acc_stb), .acc_cls(acc_cls),
  .acc_el(acc_el), .acc_secure(acc_secure), .hc_tc(hc_tc),
  .res_valid(res_valid), .res_trap(res_trap), .res_redir(res_redir),
  .res_why(res_why)
);

// File: tb/irq_acc_trap_dec_tb.sv
module irq_acc_trap_dec_tb;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst = 1;
  logic acc_stb = 0, acc_secure = 0;
  logic [2:0] acc_cls = 0;
  logic [1:0] acc_el = 0;
  logic tall0 = 0, tall1 = 0, tc = 0, tdir = 0, imo = 0, fmo = 0;
  logic res_valid, res_trap, res_redir;
  logic [2:0] res_why;

  int n_cmp = 0, n_bad = 0;
  logic       e_valid = 0, e_trap = 0, e_redir = 0;
  logic [2:0] e_why = 0;
  bit         done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_acc_trap_dec u_dut (
    .clk(clk), .rst(rst), .acc_stb(acc_stb), .acc_cls(acc_cls),
    .acc_el(acc_el), .acc_secure(acc_secure), .hc_tall0(tall0),
    .hc_tall1(tall1), .hc_tc(tc), .hc_tdir(tdir), .hc_imo(imo),
    .hc_fmo(fmo), .res_valid(res_valid), .res_trap(res_trap),
    .res_redir(res_redir), .res_why(res_why)
  );

  // Reference: reasons listed as requirements state them.
  task automatic model(output logic v, output logic t, output logic r,
                       output logic [2:0] w);
    bit all_b, dir_b, tc_b, rt_b;
    v = acc_stb; t = 0; r = 0; w = 0;
    all_b = (acc_cls == 0 && tall0) || (acc_cls == 1 && tall1);  // R4
    dir_b = (acc_cls == 2 && tdir);                               // R5
    tc_b  = (acc_cls inside {2, 3, 4}) && tc;                     // R5 R6 R7
    rt_b  = (acc_cls == 4) && (imo || fmo);                       // R7
    if (acc_stb && acc_el == 1 && !acc_secure) begin              // R3
      if (all_b)      begin t = 1; w = 1; end                     // R10
      else if (dir_b) begin t = 1; w = 2; end
      else if (tc_b)  begin t = 1; w = 3; end
      else if (rt_b)  begin t = 1; w = 4; end
      else if (imo || fmo) r = 1;                                 // R9
    end
  endtask

  // compare away from the rising edge
  always @(negedge clk) begin
    if (!rst) begin
      n_cmp++;
      if ({res_valid, res_trap, res_redir, res_why} !==
          {e_valid, e_trap, e_redir, e_why}) begin
        n_bad++;
        $display("FAIL R2/R10 cls-result: got v%0b t%0b r%0b w%0d exp v%0b t%0b r%0b w%0d",
                 res_valid, res_trap, res_redir, res_why,
                 e_valid, e_trap, e_redir, e_why);
      end
    end
  end

  always @(posedge clk) begin
    logic v, t, r;
    logic [2:0] w;
    model(v, t, r, w);
    if (rst) begin
      e_valid <= 0; e_trap <= 0; e_redir <= 0; e_why <= 0;
    end else begin
      e_valid <= v; e_trap <= t; e_redir <= r; e_why <= w;
    end
  end

  task automatic drive(input bit s, input int c, input int el, input bit sec,
                       input logic [5:0] hc);
    @(negedge clk);
    acc_stb = s; acc_cls = 3'(c); acc_el = 2'(el); acc_secure = sec;
    {tall0, tall1, tc, tdir, imo, fmo} = hc;
  endtask

  task automatic spot(input string tag, input logic t, input logic r,
                      input logic [2:0] w);
    @(negedge clk);
    acc_stb = 0;
    #1;
    n_cmp++;
    if (res_trap !== t || res_redir !== r || res_why !== w) begin
      n_bad++;
      $display("FAIL %s: got t%0b r%0b w%0d exp t%0b r%0b w%0d",
               tag, res_trap, res_redir, res_why, t, r, w);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    n_cmp++;  // R1 reset state
    if (res_valid !== 0 || res_trap !== 0 || res_redir !== 0 || res_why !== 0) begin
      n_bad++;
      $display("FAIL R1: reset outputs v%0b t%0b r%0b w%0d exp 0", res_valid,
               res_trap, res_redir, res_why);
    end
    @(negedge clk); rst = 0;
    // directed corner cases
    drive(1, 4, 1, 0, 6'b000010); spot("R7 routing trap", 1, 0, 4);
    drive(1, 2, 1, 0, 6'b001100); spot("R10 deact over tc", 1, 0, 2);
    drive(1, 0, 1, 0, 6'b101111); spot("R4 tall0", 1, 0, 1);
    drive(1, 1, 1, 0, 6'b011111); spot("R4 tall1", 1, 0, 1);
    drive(1, 3, 1, 0, 6'b110100); spot("R6 no tc", 0, 0, 0);
    drive(1, 3, 1, 0, 6'b001000); spot("R6 tc", 1, 0, 3);
    drive(1, 5, 1, 0, 6'b111111); spot("R8 free redir", 0, 1, 0);
    drive(1, 7, 1, 0, 6'b111100); spot("R8 reserved", 0, 0, 0);
    drive(1, 0, 1, 1, 6'b111111); spot("R3 secure", 0, 0, 0);
    drive(1, 4, 2, 0, 6'b111111); spot("R3 level 2", 0, 0, 0);
    drive(1, 0, 1, 0, 6'b010001); spot("R9 redirect", 0, 1, 0);
    drive(1, 2, 1, 0, 6'b000000); spot("R5 quiet", 0, 0, 0);
    // exhaustive sweep, compared each clock
    for (int c = 0; c < 8; c++)
      for (int el = 0; el < 4; el++)
        for (int s = 0; s < 2; s++)
          for (int h = 0; h < 64; h++)
            drive(1, c, el, s[0], 6'(h));
    // random with gaps
    for (int i = 0; i < 3000; i++)
      drive($urandom_range(0, 1) == 1, $urandom_range(0, 7),
            $urandom_range(0, 3), $urandom_range(0, 1) == 1, 6'($urandom));
    drive(0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout exp completion");
      end
    join_any
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule